// File: doc/BRIEF.md
# Protected Chip-Select Decoder

This block watches a 68000-style asynchronous bus cycle (address strobe, 32-bit address, 3-bit function code, read/write line) and compares the address against a set of programmable chip-select windows. Each window has a base, a mask, an enable, a read-only attribute and a wait count of 0 to 7 clocks. A window that matches drives its own active-low select. The block returns a data-transfer acknowledge once the wait count has elapsed. The on-chip register window at the top of the address space is decoded on its own output. A mirror of that window in the 24-bit view is enabled after reset.

A write to a read-only window is refused. That window's select stays inactive, no acknowledge is returned, a one-clock violation pulse and a sticky flag are raised, and a bus error is signalled if the bus-error enable bit is set. Interrupt-acknowledge cycles (function code 7) never decode. Windows are not checked against each other, so overlapping windows select together. The two control bits (bus-error enable and mirror enable) are loaded through a simple write strobe.

Top module: `csdec`

## Requirements
- R1: Window i matches when its enable is 1 and (addr AND mask_i) equals (base_i AND mask_i). Let k be the first rising edge at which as_n is sampled low. A matching window's cs_n[i] is low from edge k until the edge after as_n is sampled high. A disabled window never matches.
- R2: Windows are not checked for overlap. For an address inside two windows, both selects assert in the same cycle. The wait count used is the one of the lowest-index matching window.
- R3: A write (rw=0) that matches a window whose read-only bit is 1 keeps that window's select high. No acknowledge is returned for the whole cycle, even if another overlapping window also matches.
- R4: On such a refused write, berr_n goes low from edge k to the end of the cycle only when the bus-error enable bit is 1. With the bit at 0, berr_n stays high.
- R5: While fc equals 3'd7, no select matches and the register window does not match.
- R6: An address in 0xFFFFF000..0xFFFFFFFF drives reg_sel_n low from edge k and is acknowledged with zero wait states.
- R7: While the mirror bit is 1, addresses 0x00FFF000..0x00FFFFFF also drive reg_sel_n. A ctl_wr pulse loads the mirror bit from ctl_dmap and the bus-error enable bit from ctl_beten.
- R8: For a cycle that is accepted with wait count w, dtack_n goes low at edge k+1+w and stays low until the edge after as_n is sampled high.
- R9: A cycle that hits neither a window nor the register window returns neither dtack_n nor berr_n. dtack_n and berr_n are never low together.
- R10: A refused write raises wpv_pulse for exactly one clock, starting at edge k. It also sets wpv_flag, which stays 1 until a wpv_clr pulse. A set in the same clock as a clear takes priority.
- R11: After reset, all selects, reg_sel_n, dtack_n and berr_n are high and wpv_flag is 0. The bus-error enable bit is 0 and the mirror bit is 1.
- R12: At the edge after as_n is sampled high, all selects, reg_sel_n, dtack_n and berr_n return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, low for the length of a bus cycle |
| addr | input | 32 | Bus address |
| fc | input | 3 | Function code |
| rw | input | 1 | 1 = read, 0 = write |
| win_base | input | NCS*32 | Base address per window, window i at bits [32i+31:32i] |
| win_mask | input | NCS*32 | Compare mask per window |
| win_en | input | NCS | Window enable |
| win_ro | input | NCS | Window read-only attribute |
| win_wait | input | NCS*WW | Wait count per window |
| ctl_wr | input | 1 | Load strobe for the control bits |
| ctl_beten | input | 1 | Bus-error enable value to load |
| ctl_dmap | input | 1 | Mirror enable value to load |
| wpv_clr | input | 1 | Clear the sticky violation flag |
| cs_n | output | NCS | Active-low selects, one per window |
| reg_sel_n | output | 1 | Active-low register-window select |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| berr_n | output | 1 | Active-low bus error |
| wpv_pulse | output | 1 | One-clock write-protect violation pulse |
| wpv_flag | output | 1 | Sticky write-protect violation flag |

## Verification
The assertions assume that addr, fc and rw stay stable while as_n is low. They also assume that the window configuration and the control bits change only between cycles. The bench drives every bus cycle from one task that sets these inputs at a falling clock edge, holds as_n low for a fixed twelve clocks and then idles. It touches configuration and ctl_wr only while as_n is high, so every property sees the well-formed cycles it was written for.

// File: rtl/csdec.sv
module csdec #(
  parameter int NCS = 4,
  parameter int WW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [31:0]       addr,
  input  logic [2:0]        fc,
  input  logic              rw,
  input  logic [NCS*32-1:0] win_base,
  input  logic [NCS*32-1:0] win_mask,
  input  logic [NCS-1:0]    win_en,
  input  logic [NCS-1:0]    win_ro,
  input  logic [NCS*WW-1:0] win_wait,
  input  logic              ctl_wr,
  input  logic              ctl_beten,
  input  logic              ctl_dmap,
  input  logic              wpv_clr,
  output logic [NCS-1:0]    cs_n,
  output logic              reg_sel_n,
  output logic              dtack_n,
  output logic              berr_n,
  output logic              wpv_pulse,
  output logic              wpv_flag
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  st_t             st;
  logic [WW-1:0]   cnt;
  logic [WW-1:0]   sel_wait;
  logic [NCS-1:0]  hit, blk, pass;
  logic            fc_ok, reg_hit, any_blk, any_pass, start;
  logic            beten_q, dmap_q, blk_cyc, arm;

  assign fc_ok = (fc != 3'd7);

  for (genvar i = 0; i < NCS; i++) begin : g_win
    assign hit[i]  = win_en[i] & fc_ok &
                     ((addr & win_mask[i*32 +: 32]) == (win_base[i*32 +: 32] & win_mask[i*32 +: 32]));
    assign blk[i]  = hit[i] & win_ro[i] & ~rw;
    assign pass[i] = hit[i] & ~blk[i];
  end

  assign reg_hit  = fc_ok & ((addr[31:12] == 20'hFFFFF) |
                    (dmap_q & (addr[31:24] == 8'h00) & (addr[23:12] == 12'hFFF)));
  assign any_blk  = |blk;
  assign any_pass = (|pass) | reg_hit;
  assign start    = (st == S_IDLE) & ~as_n;

  always_comb begin
    sel_wait = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (pass[i]) sel_wait = win_wait[i*WW +: WW];
    if (reg_hit) sel_wait = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beten_q <= 1'b0;
      dmap_q  <= 1'b1;
    end else if (ctl_wr) begin
      beten_q <= ctl_beten;
      dmap_q  <= ctl_dmap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      cs_n      <= '1;
      reg_sel_n <= 1'b1;
      dtack_n   <= 1'b1;
      berr_n    <= 1'b1;
      blk_cyc   <= 1'b0;
    end else if (as_n) begin
      st        <= S_IDLE;
      cs_n      <= '1;
      reg_sel_n <= 1'b1;
      dtack_n   <= 1'b1;
      berr_n    <= 1'b1;
      blk_cyc   <= 1'b0;
    end else begin
      cs_n      <= ~pass;
      reg_sel_n <= ~reg_hit;
      unique case (st)
        S_IDLE: begin
          blk_cyc <= any_blk;
          if (any_blk) begin
            berr_n <= ~beten_q;
            st     <= S_DONE;
          end else if (any_pass) begin
            cnt <= sel_wait;
            st  <= S_WAIT;
          end else begin
            st <= S_DONE;
          end
        end
        S_WAIT: begin
          if (cnt == '0) begin
            dtack_n <= 1'b0;
            st      <= S_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpv_pulse <= 1'b0;
      wpv_flag  <= 1'b0;
      arm       <= 1'b0;
    end else begin
      arm       <= 1'b1;
      wpv_pulse <= start & any_blk;
      if (start & any_blk) wpv_flag <= 1'b1;
      else if (wpv_clr)    wpv_flag <= 1'b0;
    end
  end

  assert_fc7_nomatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm && $past(!as_n) && $past(fc) == 3'd7 |-> (&cs_n) && reg_sel_n);

  assert_ro_noack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cyc |-> dtack_n);

  assert_berr_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm && $fell(berr_n) |-> $past(beten_q));

  assert_ack_berr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !berr_n));

  assert_wpv_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wpv_pulse |-> wpv_flag);

  assert_wpv_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wpv_pulse |=> !wpv_pulse);

  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arm && $past(as_n) |-> (&cs_n) && reg_sel_n && dtack_n && berr_n);

endmodule

// File: tb/sim_csdec.sv
module sim_csdec;
  localparam int CLK_PERIOD = 10;
  localparam int NCS  = 4;
  localparam int WW   = 3;
  localparam int HOLD = 12;

  logic clk = 0, rst_n = 0, as_n = 1, rw = 1;
  logic [31:0] addr = '0;
  logic [2:0]  fc = 3'd5;
  logic [NCS*32-1:0] win_base, win_mask;
  logic [NCS-1:0] win_en, win_ro;
  logic [NCS*WW-1:0] win_wait;
  logic ctl_wr = 0, ctl_beten = 0, ctl_dmap = 1, wpv_clr = 0;
  logic [NCS-1:0] cs_n;
  logic reg_sel_n, dtack_n, berr_n, wpv_pulse, wpv_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] cs;
    logic       rsel;
    int         lat;
    logic       berr;
    int         wpv;
    string      req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csdec #(.NCS(NCS), .WW(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .fc(fc), .rw(rw),
    .win_base(win_base), .win_mask(win_mask), .win_en(win_en), .win_ro(win_ro),
    .win_wait(win_wait), .ctl_wr(ctl_wr), .ctl_beten(ctl_beten), .ctl_dmap(ctl_dmap),
    .wpv_clr(wpv_clr), .cs_n(cs_n), .reg_sel_n(reg_sel_n), .dtack_n(dtack_n),
    .berr_n(berr_n), .wpv_pulse(wpv_pulse), .wpv_flag(wpv_flag));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [31:0] a, input logic [2:0] f, input logic r,
                           input logic [3:0] ecs, input logic ersel, input int elat,
                           input logic eberr, input int ewpv, input string req);
    exp_t e;
    e.cs = ecs; e.rsel = ersel; e.lat = elat; e.berr = eberr; e.wpv = ewpv; e.req = req;
    q.push_back(e);
    @(negedge clk);
    addr = a; fc = f; rw = r; as_n = 0;
    repeat (HOLD) @(negedge clk);
    as_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl_load(input logic be, input logic dm);
    @(negedge clk);
    ctl_beten = be; ctl_dmap = dm; ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  initial begin : monitor
    forever begin
      logic [3:0] cs_obs;
      logic rs_obs, berr_obs, rel_ok;
      int lat, wpvs;
      exp_t e;
      @(negedge as_n);
      lat = -1; wpvs = 0; berr_obs = 0;
      cs_obs = '0; rs_obs = 0;
      for (int c = 0; c < HOLD; c++) begin
        @(negedge clk);
        if (c == 0) begin
          cs_obs = ~cs_n;
          rs_obs = ~reg_sel_n;
        end
        if (!dtack_n && lat < 0) lat = c;
        if (!berr_n) berr_obs = 1;
        if (wpv_pulse) wpvs++;
      end
      @(negedge clk);
      rel_ok = (&cs_n) && reg_sel_n && dtack_n && berr_n;
      e = q.pop_front();
      check(cs_obs == e.cs, e.req, "selects", cs_obs, e.cs);
      check(rs_obs == e.rsel, e.req, "reg_sel", rs_obs, e.rsel);
      check(lat == e.lat, e.req, "dtack latency", lat, e.lat);
      check(berr_obs == e.berr, e.req, "berr", berr_obs, e.berr);
      check(wpvs == e.wpv, e.req, "wpv pulses", wpvs, e.wpv);
      check(rel_ok, "R12", "release after strobe", rel_ok, 1);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    win_base = {32'h0080_0000, 32'h0040_0000, 32'h0018_0000, 32'h0010_0000};
    win_mask = {32'hFFFF_0000, 32'hFFFF_0000, 32'hFFF8_0000, 32'hFFF0_0000};
    win_en   = 4'b0111;
    win_ro   = 4'b0100;
    win_wait = {3'd7, 3'd0, 3'd5, 3'd2};
    repeat (3) @(negedge clk);
    check(&cs_n, "R11", "selects at reset", cs_n, 4'hF);
    check(reg_sel_n && dtack_n && berr_n, "R11", "strobes at reset",
          {reg_sel_n, dtack_n, berr_n}, 3'b111);
    check(!wpv_flag, "R11", "flag at reset", wpv_flag, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R8: single window, wait 2 -> dtack seen after edge k+3
    bus_cycle(32'h0010_0010, 3'd5, 1, 4'b0001, 0, 3, 0, 0, "R1");
    // R2: overlap, both select, window 0 wait used
    bus_cycle(32'h0018_0004, 3'd5, 1, 4'b0011, 0, 3, 0, 0, "R2");
    bus_cycle(32'h0018_0000, 3'd6, 0, 4'b0011, 0, 3, 0, 0, "R2");
    // R3 R4: refused write with bus-error enable 0 (reset value, R11)
    bus_cycle(32'h0040_0000, 3'd5, 0, 4'b0000, 0, -1, 0, 1, "R3");
    @(negedge clk);
    check(wpv_flag, "R10", "flag after refused write", wpv_flag, 1);
    wpv_clr = 1; @(negedge clk); wpv_clr = 0; @(negedge clk);
    check(!wpv_flag, "R10", "flag after clear", wpv_flag, 0);
    ctl_load(1, 1);
    bus_cycle(32'h0040_0000, 3'd5, 0, 4'b0000, 0, -1, 1, 1, "R4");
    // read of read-only window allowed, wait 0
    bus_cycle(32'h0040_0000, 3'd5, 1, 4'b0100, 0, 1, 0, 0, "R3");
    // R5: interrupt acknowledge space never matches
    bus_cycle(32'h0010_0010, 3'd7, 1, 4'b0000, 0, -1, 0, 0, "R5");
    bus_cycle(32'hFFFF_F010, 3'd7, 1, 4'b0000, 0, -1, 0, 0, "R5");
    // R9 and R1: disabled window does not match, nothing returned
    bus_cycle(32'h0080_0000, 3'd5, 1, 4'b0000, 0, -1, 0, 0, "R9");
    // R6 R7: register window and its mirror
    bus_cycle(32'hFFFF_F010, 3'd5, 1, 4'b0000, 1, 1, 0, 0, "R6");
    bus_cycle(32'h00FF_F010, 3'd5, 1, 4'b0000, 1, 1, 0, 0, "R7");
    ctl_load(1, 0);
    bus_cycle(32'h00FF_F010, 3'd5, 1, 4'b0000, 0, -1, 0, 0, "R7");
    bus_cycle(32'hFFFF_F000, 3'd5, 0, 4'b0000, 1, 1, 0, 0, "R6");
    // R8: enable window 3 with the maximum wait of 7
    win_en = 4'b1111;
    bus_cycle(32'h0080_1234, 3'd2, 1, 4'b1000, 0, 8, 0, 0, "R8");
    // R3: refused write overlapping a writable window: no ack
    win_base[2*32 +: 32] = 32'h0010_0000;
    win_mask[2*32 +: 32] = 32'hFFFF_0000;
    bus_cycle(32'h0010_0100, 3'd5, 0, 4'b0001, 0, -1, 1, 1, "R3");
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule